// File: doc/BRIEF.md
# Pipeline Miss Stall Controller

This block is the hazard-control logic that keeps an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) consistent while either memory port is waiting on a miss. It reads two level-sensitive miss indications, one from the instruction port and one from the data port. From these it drives an enable and a bubble strobe for each pipeline register. Bit 0 of each vector belongs to the program counter. Bit k (k ≥ 1) belongs to the instruction register that feeds stage k: 1 decode, 2 execute, 3 memory, 4 writeback.

An instruction miss holds the program counter and pushes a no-op into decode on every cycle, while the older instructions drain and retire. A data miss freezes the memory stage and everything in front of it, and feeds bubbles to writeback so that nothing retires until the miss is over. When both misses are raised together, the data miss wins. The pipeline writes a bubble as an all-zero instruction word with its stage-valid bit cleared, so a bubble makes no register or memory write. The controller is purely combinational. A miss therefore acts in the cycle it is raised, and normal flow returns in the first cycle where it is low.

Top module: `stall_ctl`

## Requirements
- R1: With neither miss raised, every bit of `stage_en` is 1 and every bit of `stage_bub` is 0.
- R2: With only the instruction miss raised, `stage_en[0]` (program counter) is 0, so the program counter is not updated.
- R3: With only the instruction miss raised, `stage_bub[1]` and `stage_en[1]` are both 1, so decode receives a no-op every cycle.
- R4: With only the instruction miss raised, the execute, memory and writeback registers (bits 2 to 4) are enabled with no bubble, so older instructions keep advancing.
- R5: With the data miss raised, bits 0 to 3 of `stage_en` (program counter through the memory register) are 0, and none of those bits carries a bubble.
- R6: With the data miss raised, `stage_bub[4]` and `stage_en[4]` are both 1, so writeback receives a bubble each cycle.
- R7: With both misses raised, the outputs equal the data-miss-only outputs.
- R8: Any bit with a bubble is also enabled, `stage_bub[0]` is always 0, and at most one bubble bit is set.
- R9: The outputs depend only on the present miss levels, so the first cycle in which the misses are low already shows normal flow (R1 values).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imiss | input | 1 | Instruction-port miss outstanding (level) |
| dmiss | input | 1 | Data-port miss outstanding (level) |
| stage_en | output | NSTAGE | Load enable per register; bit 0 program counter, bit k register feeding stage k |
| stage_bub | output | NSTAGE | Load a no-op in place of the incoming instruction, per register |

## Verification
Every result is due in the same cycle as its stimulus, because there is no register between the miss inputs and the outputs. The bench changes the inputs just after a rising edge and compares the outputs at the following falling edge, so each comparison covers exactly one input pair. For R9, a run of miss cycles is followed by a cycle with both misses low, and that cycle is checked against normal flow. Random miss patterns drawn from a fixed seed are compared against a bench function built from the requirements.

// File: rtl/stall_ctl_pkg.sv
package stall_ctl_pkg;
   typedef enum logic [1:0] {
      MODE_FLOW   = 2'd0,
      MODE_IFILL  = 2'd1,
      MODE_FREEZE = 2'd2
   } stall_mode_e;
endpackage

// File: rtl/stall_arbiter.sv
module stall_arbiter
   import stall_ctl_pkg::*;
(
   input  logic        imiss_i,
   input  logic        dmiss_i,
   output stall_mode_e mode_o
);
   always_comb begin
      if (dmiss_i)      mode_o = MODE_FREEZE;
      else if (imiss_i) mode_o = MODE_IFILL;
      else              mode_o = MODE_FLOW;
   end
endmodule

// File: rtl/stall_slice.sv
module stall_slice
   import stall_ctl_pkg::*;
#(
   parameter int IDX     = 0,
   parameter int MEM_IDX = 3
) (
   input  stall_mode_e mode_i,
   output logic        en_o,
   output logic        bub_o
);
   generate
      if (IDX == 0) begin : g_pc
         assign en_o  = (mode_i == MODE_FLOW);
         assign bub_o = 1'b0;
      end else if (IDX == 1) begin : g_dec
         assign en_o  = (mode_i != MODE_FREEZE);
         assign bub_o = (mode_i == MODE_IFILL);
      end else if (IDX <= MEM_IDX) begin : g_front
         assign en_o  = (mode_i != MODE_FREEZE);
         assign bub_o = 1'b0;
      end else if (IDX == MEM_IDX + 1) begin : g_retire
         assign en_o  = 1'b1;
         assign bub_o = (mode_i == MODE_FREEZE);
      end else begin : g_tail
         assign en_o  = 1'b1;
         assign bub_o = 1'b0;
      end
   endgenerate

   always_comb begin
      // R8
      bub_en_chk: assert (!bub_o || en_o)
         else $error("bubble without enable at register %0d", IDX);
   end
endmodule

// File: rtl/stall_ctl.sv
module stall_ctl
   import stall_ctl_pkg::*;
#(
   parameter int NSTAGE  = 5,
   parameter int MEM_IDX = 3
) (
   input  logic              imiss,
   input  logic              dmiss,
   output logic [NSTAGE-1:0] stage_en,
   output logic [NSTAGE-1:0] stage_bub
);
   localparam int FREEZE_N = MEM_IDX + 1;

   generate
      if (NSTAGE < 4 || MEM_IDX < 2 || MEM_IDX > NSTAGE - 2) begin : g_bad_cfg
         $error("stall_ctl: NSTAGE/MEM_IDX out of range");
      end
   endgenerate

   stall_mode_e mode;

   stall_arbiter u_arb (
      .imiss_i (imiss),
      .dmiss_i (dmiss),
      .mode_o  (mode)
   );

   genvar k;
   generate
      for (k = 0; k < NSTAGE; k++) begin : g_stage
         stall_slice #(.IDX(k), .MEM_IDX(MEM_IDX)) u_slice (
            .mode_i (mode),
            .en_o   (stage_en[k]),
            .bub_o  (stage_bub[k])
         );
      end
   endgenerate

   always_comb begin
      // R1
      flow_chk: assert ((imiss || dmiss) || (&stage_en && !(|stage_bub)))
         else $error("flow cycle not fully enabled");
      // R2
      pc_hold_chk: assert (!(imiss || dmiss) || !stage_en[0])
         else $error("pc enabled during miss");
      // R5
      freeze_chk: assert (!dmiss || (stage_en[FREEZE_N-1:0] == '0))
         else $error("front stage enabled during data miss");
      // R6
      retire_bub_chk: assert (!dmiss || stage_bub[FREEZE_N])
         else $error("writeback not bubbled during data miss");
      // R8
      one_bub_chk: assert ($onehot0(stage_bub) && !stage_bub[0])
         else $error("bubble vector malformed");
   end
endmodule

// File: tb/sim_stall_ctl.sv
module sim_stall_ctl;
   localparam int NS = 5;

   logic          clk = 1'b0;
   logic          imiss = 1'b0;
   logic          dmiss = 1'b0;
   logic [NS-1:0] stage_en;
   logic [NS-1:0] stage_bub;
   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done  = 1'b0;

   always #2 clk = ~clk;

   stall_ctl #(.NSTAGE(NS), .MEM_IDX(3)) u0 (
      .imiss     (imiss),
      .dmiss     (dmiss),
      .stage_en  (stage_en),
      .stage_bub (stage_bub)
   );

   function automatic logic [NS-1:0] exp_en(input logic im, input logic dm);
      if (dm)      return 5'b10000;
      else if (im) return 5'b11110;
      else         return 5'b11111;
   endfunction

   function automatic logic [NS-1:0] exp_bub(input logic im, input logic dm);
      if (dm)      return 5'b10000;
      else if (im) return 5'b00010;
      else         return 5'b00000;
   endfunction

   task automatic cmp(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b (imiss=%b dmiss=%b)", req, act, exp, imiss, dmiss);
      end
   endtask

   task automatic apply(input logic im, input logic dm);
      @(posedge clk);
      #1;
      imiss = im;
      dmiss = dm;
      @(negedge clk);
   endtask

   task automatic check_now(input string tag_en, input string tag_bub);
      cmp(tag_en, stage_en, exp_en(imiss, dmiss));
      cmp(tag_bub, stage_bub, exp_bub(imiss, dmiss));
      // R8 bubble implies enable
      cmp("R8", stage_bub & ~stage_en, '0);
   endtask

   task automatic check_mode();
      if (imiss && dmiss)  check_now("R7", "R7");
      else if (dmiss)      check_now("R5", "R6");
      else if (imiss)      check_now("R2", "R3");
      else                 check_now("R1", "R1");
   endtask

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'h5A17);
      // reset state: no misses
      apply(1'b0, 1'b0);
      check_now("R1", "R1");
      // instruction miss held several cycles
      for (int i = 0; i < 3; i++) begin
         apply(1'b1, 1'b0);
         cmp("R2", {4'b0, stage_en[0]}, 5'b0);
         cmp("R3", {3'b0, stage_en[1], stage_bub[1]}, 5'b00011);
         cmp("R4", {2'b0, stage_en[4:2]}, 5'b00111);
         cmp("R4", {2'b0, stage_bub[4:2]}, 5'b0);
      end
      apply(1'b0, 1'b0);
      check_now("R9", "R9");
      // data miss held several cycles
      for (int i = 0; i < 4; i++) begin
         apply(1'b0, 1'b1);
         cmp("R5", {1'b0, stage_en[3:0]}, 5'b0);
         cmp("R5", {1'b0, stage_bub[3:0]}, 5'b0);
         cmp("R6", {3'b0, stage_en[4], stage_bub[4]}, 5'b00011);
      end
      apply(1'b0, 1'b0);
      check_now("R9", "R9");
      // both, then data clears while instruction miss stays
      apply(1'b1, 1'b1);
      check_now("R7", "R7");
      apply(1'b1, 1'b0);
      check_now("R2", "R3");
      apply(1'b0, 1'b0);
      check_now("R9", "R9");
      // random patterns
      for (int i = 0; i < 400; i++) begin
         logic [1:0] r;
         r = 2'($urandom());
         apply(r[0], r[1]);
         check_mode();
         cmp("R8", {4'b0, stage_bub[0]}, 5'b0);
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule